// File: doc/BRIEF.md
# Byte-Lane Aligning Memory Wrapper

This block connects a processor's load/store port to word-wide storage. The core issues byte addresses, and each request moves a byte, a halfword or a word. Byte accesses may use any address, halfword accesses must be 2-aligned and word accesses must be 4-aligned. The wrapper drops the two low address bits to get a word index. On a store it moves the write data and the byte enables up to the byte lanes named by those two bits. On a load it reads the whole word and shifts it back down to bit 0, filling the top with zeros.

The address space holds two mapped regions: a data store and a second memory-mapped store. Each region has its own word storage inside the wrapper. Every other address is unmapped. The storage has one cycle of read latency, so the byte offset and region of each request are registered. In the next cycle those registered values steer the read mux and the right shifter. Loads are never sign-extended and misaligned accesses are not trapped.

Top module: `mem_lane_wrap`

## Requirements
- R1: A request selects the word at index reqAddr[9:2] (default depth 256 words). Byte addresses that differ only in bits [1:0] reach the same stored word.
- R2: A store at byte offset 1 writes data {reqWdata[23:0], 8'h00} under enables {reqBe[2:0], 1'b0}. Enable bit k guards bits [8k+7:8k].
- R3: A store at byte offset 2 writes data {reqWdata[15:0], 16'h0000} under enables {reqBe[1:0], 2'b00}.
- R4: A store at byte offset 3 writes data {reqWdata[7:0], 24'h000000} under enables {reqBe[0], 3'b000}. For example, byte 0x10 stored at 0x07 sets only the top byte of word 1 to 0x10.
- R5: A store at byte offset 0 passes data and enables through unchanged.
- R6: A store changes only the byte lanes whose shifted enable is set. Every other byte of the word keeps its previous value.
- R7: A load (reqValid=1, reqWe=0) presents the addressed word on rspRdata one clock edge after the request. The word is shifted right by 8 times the byte offset, with zeros in the vacated upper bits. reqBe has no effect on loads.
- R8: The shift and the region select use the offset and region registered from the last accepted request. rspRdata stays unchanged across cycles with reqValid=0.
- R9: Address bits [31:16] = 0x0000 select the data region and 0x0001 select the memory-mapped region. The two regions hold separate storage.
- R10: An address is unmapped if its tag is any other value, or if bits [15:10] are non-zero (beyond the storage depth). An unmapped load returns zero and an unmapped store changes no stored byte.
- R11: After reset, rspRdata is zero until the first load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present this cycle |
| reqWe | input | 1 | 1 for a store, 0 for a load |
| reqAddr | input | 32 | Byte address of the access |
| reqWdata | input | 32 | Store data, right-aligned at bit 0 |
| reqBe | input | 4 | Core-side byte enables, bit 0 is the lowest byte |
| rspRdata | output | 32 | Load result, right-aligned, zero-filled |

## Verification
The bench keeps a byte-array model of both regions. It runs stores and loads at every legal offset, in every size, and compares each load's full 32 bits.

Each corner case below shows how a particular fault would appear:
- A byte at offset 3 that landed in the wrong lane would show up when the whole word is read back.
- A load realigned with the live offset instead of the registered one would break as soon as consecutive requests differ in offset. The bench also watches rspRdata through idle cycles.
- Stores to an unregistered tag, or beyond the storage depth, are each followed by a read of the aliased word in both mapped regions. A design that wrapped the index or ignored the tag would corrupt one of those reads.

// File: rtl/memlane_pkg.sv
package memlane_pkg;

  typedef enum logic [1:0] {
    RGN_NONE = 2'd0,
    RGN_DATA = 2'd1,
    RGN_MMIO = 2'd2
  } region_e;

  typedef struct packed {
    logic wrData;
    logic rdData;
    logic wrMmio;
    logic rdMmio;
  } laneStrobe_t;

endpackage

// File: rtl/memlane_ctrl.sv
module memlane_ctrl
  import memlane_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int OFF_W      = 2,
  parameter int IDX_W      = 8,
  parameter int REGION_LSB = 16,
  parameter int DATA_TAG   = 0,
  parameter int MMIO_TAG   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  input  logic              reqWe,
  input  logic [ADDR_W-1:0] reqAddr,
  output laneStrobe_t       strobe,
  output logic [IDX_W-1:0]  wordIdx,
  output logic [OFF_W-1:0]  reqOff,
  output logic [OFF_W-1:0]  offQ,
  output region_e           regionQ
);

  localparam int TAG_W = ADDR_W - REGION_LSB;
  localparam int GAP_LSB = OFF_W + IDX_W;
  localparam int GAP_W = REGION_LSB - GAP_LSB;

  logic [TAG_W-1:0] tag;
  logic             gapClear;
  region_e          regionD;

  assign tag     = reqAddr[ADDR_W-1:REGION_LSB];
  assign wordIdx = reqAddr[OFF_W +: IDX_W];
  assign reqOff  = reqAddr[OFF_W-1:0];

  // Addresses past the storage depth inside a region are treated as unmapped
  generate
    if (GAP_W > 0) begin : g_gap
      assign gapClear = (reqAddr[REGION_LSB-1:GAP_LSB] == '0);
    end else begin : g_nogap
      assign gapClear = 1'b1;
    end
  endgenerate

  always_comb begin
    regionD = RGN_NONE;
    if (gapClear) begin
      if (tag == TAG_W'(DATA_TAG))      regionD = RGN_DATA;
      else if (tag == TAG_W'(MMIO_TAG)) regionD = RGN_MMIO;
    end
  end

  always_comb begin
    strobe.wrData = reqValid &&  reqWe && (regionD == RGN_DATA);
    strobe.rdData = reqValid && !reqWe && (regionD == RGN_DATA);
    strobe.wrMmio = reqValid &&  reqWe && (regionD == RGN_MMIO);
    strobe.rdMmio = reqValid && !reqWe && (regionD == RGN_MMIO);
  end

  // Offset and region follow the request by one cycle to meet the read latency
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      offQ    <= '0;
      regionQ <= RGN_NONE;
    end else if (reqValid) begin
      offQ    <= reqOff;
      regionQ <= regionD;
    end
  end

  p_unmapped_nowrite_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && (tag != TAG_W'(DATA_TAG)) && (tag != TAG_W'(MMIO_TAG)))
      |-> !(strobe.wrData || strobe.wrMmio || strobe.rdData || strobe.rdMmio));

  p_steer_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !reqValid |=> ($stable(offQ) && $stable(regionQ)));

  p_one_target_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strobe.wrData, strobe.rdData, strobe.wrMmio, strobe.rdMmio}));

endmodule

// File: rtl/memlane_datapath.sv
module memlane_datapath
  import memlane_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANES  = DATA_W / 8,
  parameter int OFF_W  = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OFF_W-1:0]  reqOff,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [LANES-1:0]  reqBe,
  input  logic [OFF_W-1:0]  offQ,
  input  region_e           regionQ,
  input  logic [DATA_W-1:0] dataWord,
  input  logic [DATA_W-1:0] mmioWord,
  output logic [DATA_W-1:0] wrWord,
  output logic [LANES-1:0]  wrBe,
  output logic [DATA_W-1:0] rspRdata
);

  localparam int SH_W = OFF_W + 3;

  logic [SH_W-1:0]   wrShift;
  logic [SH_W-1:0]   rdShift;
  logic [DATA_W-1:0] selWord;

  assign wrShift = {reqOff, 3'b000};
  assign rdShift = {offQ, 3'b000};

  // Store side: lanes move up in the request cycle
  always_comb begin
    wrWord = reqWdata << wrShift;
    wrBe   = reqBe << reqOff;
  end

  // Load side: pick the region registered last cycle, then move down with zero fill
  always_comb begin
    unique case (regionQ)
      RGN_DATA: selWord = dataWord;
      RGN_MMIO: selWord = mmioWord;
      default:  selWord = '0;
    endcase
    rspRdata = selWord >> rdShift;
  end

  p_lane_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wrBe) <= $countones(reqBe));

  p_low_byte_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reqOff != '0) |-> (wrWord[7:0] == 8'h00 && !wrBe[0]));

  p_zero_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (offQ == OFF_W'(LANES - 1)) |-> (rspRdata[DATA_W-1:8] == '0));

endmodule

// File: rtl/memlane_ram.sv
module memlane_ram #(
  parameter int WORDS = 256,
  parameter int LANES = 4,
  parameter int IDX_W = $clog2(WORDS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic               rd,
  input  logic [IDX_W-1:0]   idx,
  input  logic [LANES*8-1:0] wdata,
  input  logic [LANES-1:0]   be,
  output logic [LANES*8-1:0] rdata
);

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [7:0] store [WORDS];
      logic [7:0] q;

      always_ff @(posedge clk) begin
        if (we && be[g]) store[idx] <= wdata[g*8 +: 8];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= 8'h00;
        else if (rd) q <= store[idx];
      end

      assign rdata[g*8 +: 8] = q;
    end
  endgenerate

  p_read_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(rdata));

endmodule

// File: rtl/mem_lane_wrap.sv
module mem_lane_wrap
  import memlane_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int WORDS      = 256,
  parameter int REGION_LSB = 16,
  parameter int DATA_TAG   = 0,
  parameter int MMIO_TAG   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  input  logic              reqWe,
  input  logic [31:0]       reqAddr,
  input  logic [31:0]       reqWdata,
  input  logic [3:0]        reqBe,
  output logic [31:0]       rspRdata
);

  localparam int LANES = DATA_W / 8;
  localparam int OFF_W = $clog2(LANES);
  localparam int IDX_W = $clog2(WORDS);

  laneStrobe_t       strobe;
  logic [IDX_W-1:0]  wordIdx;
  logic [OFF_W-1:0]  reqOff;
  logic [OFF_W-1:0]  offQ;
  region_e           regionQ;
  logic [DATA_W-1:0] wrWord;
  logic [LANES-1:0]  wrBe;
  logic [DATA_W-1:0] dataWord;
  logic [DATA_W-1:0] mmioWord;

  memlane_ctrl #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W),
    .REGION_LSB(REGION_LSB), .DATA_TAG(DATA_TAG), .MMIO_TAG(MMIO_TAG)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqWe(reqWe),
    .reqAddr(reqAddr), .strobe(strobe), .wordIdx(wordIdx), .reqOff(reqOff),
    .offQ(offQ), .regionQ(regionQ)
  );

  memlane_datapath #(.DATA_W(DATA_W), .LANES(LANES), .OFF_W(OFF_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .reqOff(reqOff), .reqWdata(reqWdata),
    .reqBe(reqBe), .offQ(offQ), .regionQ(regionQ), .dataWord(dataWord),
    .mmioWord(mmioWord), .wrWord(wrWord), .wrBe(wrBe), .rspRdata(rspRdata)
  );

  memlane_ram #(.WORDS(WORDS), .LANES(LANES), .IDX_W(IDX_W)) u_dataRam (
    .clk(clk), .rst_n(rst_n), .we(strobe.wrData), .rd(strobe.rdData),
    .idx(wordIdx), .wdata(wrWord), .be(wrBe), .rdata(dataWord)
  );

  memlane_ram #(.WORDS(WORDS), .LANES(LANES), .IDX_W(IDX_W)) u_mmioRam (
    .clk(clk), .rst_n(rst_n), .we(strobe.wrMmio), .rd(strobe.rdMmio),
    .idx(wordIdx), .wdata(wrWord), .be(wrBe), .rdata(mmioWord)
  );

  p_unmapped_load_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && !reqWe && !strobe.rdData && !strobe.rdMmio) |=> (rspRdata == '0));

  p_single_ram_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(strobe.wrData && strobe.wrMmio));

endmodule

// File: tb/mem_lane_wrap_test.sv
`timescale 1ns/1ps
module mem_lane_wrap_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWe = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic [3:0]  reqBe = '0;
  logic [31:0] rspRdata;

  int nChecks = 0;
  int nErrors = 0;
  logic [7:0] dataMem [1024];
  logic [7:0] mmioMem [1024];

  always #2.5 clk = ~clk;

  mem_lane_wrap uut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqWe(reqWe),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqBe(reqBe), .rspRdata(rspRdata)
  );

  function automatic int regionOf(logic [31:0] a);
    if (a[15:10] != 6'd0) return 0;
    if (a[31:16] == 16'h0000) return 1;
    if (a[31:16] == 16'h0001) return 2;
    return 0;
  endfunction

  function automatic logic [31:0] expLoad(logic [31:0] a);
    logic [31:0] w;
    int base;
    int rg;
    rg = regionOf(a);
    if (rg == 0) return 32'h0;
    base = int'(a[9:2]) * 4;
    for (int k = 0; k < 4; k++)
      w[8*k +: 8] = (rg == 1) ? dataMem[base+k] : mmioMem[base+k];
    return w >> (8 * int'(a[1:0]));
  endfunction

  task automatic modelStore(logic [31:0] a, logic [31:0] d, logic [3:0] be);
    int rg;
    int off;
    int base;
    rg = regionOf(a);
    off = int'(a[1:0]);
    base = int'(a[9:2]) * 4;
    for (int k = 0; k < 4; k++) begin
      if (rg != 0 && be[k] && (k + off) < 4) begin
        if (rg == 1) dataMem[base+off+k] = d[8*k +: 8];
        else         mmioMem[base+off+k] = d[8*k +: 8];
      end
    end
  endtask

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nErrors++;
      $display("FAIL %s actual=%08h expected=%08h", req, got, exp);
    end
  endtask

  // One request; result sampled on the falling edge after the capturing edge
  task automatic access(logic we, logic [31:0] a, logic [31:0] d, logic [3:0] be,
                        output logic [31:0] got);
    @(negedge clk);
    reqValid = 1'b1; reqWe = we; reqAddr = a; reqWdata = d; reqBe = be;
    @(posedge clk);
    @(negedge clk);
    got = rspRdata;
    reqValid = 1'b0; reqWe = 1'b0;
    if (we) modelStore(a, d, be);
  endtask

  task automatic store(logic [31:0] a, logic [31:0] d, logic [3:0] be);
    logic [31:0] dummy;
    access(1'b1, a, d, be, dummy);
  endtask

  task automatic loadCheck(string req, logic [31:0] a);
    logic [31:0] got;
    access(1'b0, a, 32'h0, 4'h0, got);
    check(req, got, expLoad(a));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nErrors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end

  initial begin
    logic [31:0] got;
    logic [31:0] held;
    void'($urandom(32'h5eed_0042));
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R11", rspRdata, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11", rspRdata, 32'h0);

    for (int i = 0; i < 256; i++) begin
      store(32'h0000_0000 | (i * 4), $urandom(), 4'hF);
      store(32'h0001_0000 | (i * 4), $urandom(), 4'hF);
    end

    // R4: byte 0x10 at byte address 0x07 goes to the top lane of word 1
    store(32'h0000_0007, 32'h0000_0010, 4'h1);
    loadCheck("R4", 32'h0000_0004);
    loadCheck("R7", 32'h0000_0007);
    store(32'h0000_0021, 32'hFFFF_FFAB, 4'h1);
    loadCheck("R2", 32'h0000_0020);
    store(32'h0000_0032, 32'h1234_BEEF, 4'h3);
    loadCheck("R3", 32'h0000_0030);
    loadCheck("R7", 32'h0000_0032);
    store(32'h0000_0044, 32'hCAFE_F00D, 4'hF);
    loadCheck("R5", 32'h0000_0044);
    store(32'h0000_0049, 32'h0000_0077, 4'h1);
    loadCheck("R6", 32'h0000_0048);

    // R1: every byte address of one word maps to the same stored word
    store(32'h0000_0050, 32'hA1B2_C3D4, 4'hF);
    loadCheck("R1", 32'h0000_0051);
    loadCheck("R1", 32'h0000_0052);
    loadCheck("R1", 32'h0000_0053);
    access(1'b0, 32'h0000_0053, 32'h0, 4'hF, got);
    check("R1", got, 32'h0000_00A1);

    // R8: result holds over idle cycles
    access(1'b0, 32'h0000_0052, 32'h0, 4'h0, held);
    check("R8", held, 32'h0000_A1B2);
    repeat (3) @(negedge clk);
    check("R8", rspRdata, held);

    // R9: regions hold separate storage
    store(32'h0001_0050, 32'h0BAD_CAFE, 4'hF);
    loadCheck("R9", 32'h0001_0050);
    loadCheck("R9", 32'h0000_0050);

    // R10: unmapped tag and beyond-depth offsets
    store(32'h0002_0050, 32'hDEAD_BEEF, 4'hF);
    store(32'h0000_1050, 32'hDEAD_BEEF, 4'hF);
    store(32'h0001_0450, 32'hDEAD_BEEF, 4'hF);
    access(1'b0, 32'h0002_0050, 32'h0, 4'h0, got);
    check("R10", got, 32'h0);
    access(1'b0, 32'h0000_1050, 32'h0, 4'h0, got);
    check("R10", got, 32'h0);
    loadCheck("R10", 32'h0000_0050);
    loadCheck("R10", 32'h0001_0050);

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] a;
      logic [3:0]  be;
      int sz;
      int pick;
      pick = int'($urandom_range(0, 9));
      a = {22'h0, 8'($urandom()), 2'b00};
      if (pick < 5)       a[31:16] = 16'h0000;
      else if (pick < 9)  a[31:16] = 16'h0001;
      else                a[31:16] = 16'($urandom_range(2, 5));
      sz = int'($urandom_range(0, 2));
      if (sz == 0) begin a[1:0] = 2'($urandom()); be = 4'h1; end
      else if (sz == 1) begin a[1:0] = {1'($urandom()), 1'b0}; be = 4'h3; end
      else be = 4'hF;
      if ($urandom_range(0, 1) == 1) store(a, $urandom(), be);
      else loadCheck("R7", a);
    end

    $display("  CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end

endmodule